// File: doc/BRIEF.md
# Macro-op pair detector

This block looks at a window of eight decoded instructions, held in program order, and picks out pairs of dependent single-cycle instructions. Each pair can later share one issue-queue entry as a two-cycle scheduling unit. For every slot it produces a 4-bit pointer. On the head of a pair, the pointer gives the distance to the tail and records whether the pair spans a taken control transfer. On every other slot the pointer is zero.

Each slot supplies four things: an operation class, an optional destination register, up to two optional source registers, and a flag marking a taken control transfer. A window is presented with `valid_i`. One clock later its pointers appear on `ptr_o` together with `ptr_valid_o`. Three rules make pairing conservative. A source-operand budget limits the fused operands. A cheap test rejects pairs that could form a dependence cycle. At most one taken transfer may lie inside a pair.

Top module: `mop_pair_detect`

## Requirements
- R1: A window presented with `valid_i` high at a rising edge yields `ptr_valid_o` high and its pointers on `ptr_o` after that edge. While `valid_i` is low, `ptr_valid_o` drops on the next edge and `ptr_o` keeps its previous value.
- R2: While `rst_ni` is low, `ptr_o` is all zeros and `ptr_valid_o` is low.
- R3: The class field of slot s is `cls_i[2s+1:2s]`, with codes 00 integer ALU, 01 control, 10 store address generation and 11 long-latency. Only codes 00, 01 and 10 may be a head or a tail. A head must also have `dst_en_i` set.
- R4: The pointer of slot s is `ptr_o[4s+3:4s]`. Bits 2:0 hold the tail slot index minus the head slot index, from 1 to 7. Bit 3 is the control flag. A slot that heads no pair, including a tail, reads 0000.
- R5: A later slot depends on a head when one of its enabled sources names the head's destination and no slot between them writes that register.
- R6: A head takes the nearest later unclaimed candidate that depends on it. If that pairing fails a rule, the head stays unpaired.
- R7: Heads are resolved from slot 0 upward. A slot already used as a tail or head cannot start a pair.
- R8: Count the taken flags on the slots from the head up to the slot before the tail. A count of one sets bit 3. A count of two or more forbids the pair.
- R9: The fused source count is the head's enabled sources plus the tail's enabled sources that do not name the head's destination. It may not exceed 2 when `src3_mode_i` is 0, or 3 when it is 1.
- R10: A pair is rejected when a slot between head and tail depends on the head and the tail also depends on a slot between them. Either condition on its own is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Window present this cycle |
| src3_mode_i | input | 1 | Allow three fused sources instead of two |
| cls_i | input | 16 | Operation class per slot |
| dst_i | input | 40 | Destination register per slot |
| dst_en_i | input | 8 | Destination valid per slot |
| src_a_i | input | 40 | First source register per slot |
| src_a_en_i | input | 8 | First source valid per slot |
| src_b_i | input | 40 | Second source register per slot |
| src_b_en_i | input | 8 | Second source valid per slot |
| taken_i | input | 8 | Taken control transfer per slot |
| ptr_valid_o | output | 1 | Pointers valid |
| ptr_o | output | 32 | 4-bit pointer per slot |

## Verification
The windows fall into matched groups, so that each rule is shown to decide the outcome.

Simple adjacent and distant dependences establish the pointer layout and the largest offset. Windows where the nearest consumer is a long-latency slot, or where an intervening writer redefines the register, separate candidacy from true dependence. Chained consumers show that a tail cannot become a head.

Three further contrasts isolate the remaining rules. Windows with one and with two taken transfers test the control rule. The same over-budget window is sent in both source modes, beside a tail whose two sources both name the head. A cycle-shaped window is paired with one that has only an incoming edge.

// File: rtl/mop_pkg.sv
package mop_pkg;
  typedef enum logic [1:0] {
    CLS_ALU  = 2'b00,
    CLS_CTRL = 2'b01,
    CLS_STA  = 2'b10,
    CLS_LONG = 2'b11
  } op_cls_e;
endpackage

// File: rtl/mop_dep_matrix.sv
// dep_o[a*W+b]: slot b reads the value slot a produces (no intervening redefinition)
module mop_dep_matrix #(
  parameter int W  = 8,
  parameter int RW = 5
) (
  input  logic [W*RW-1:0] dst_i,
  input  logic [W-1:0]    dst_en_i,
  input  logic [W*RW-1:0] src_a_i,
  input  logic [W-1:0]    src_a_en_i,
  input  logic [W*RW-1:0] src_b_i,
  input  logic [W-1:0]    src_b_en_i,
  output logic [W*W-1:0]  dep_o
);
  logic rd, killed;

  always_comb begin
    dep_o = '0;
    for (int a = 0; a < W; a++) begin
      for (int b = 0; b < W; b++) begin
        rd = (src_a_en_i[b] && src_a_i[b*RW+:RW] == dst_i[a*RW+:RW]) ||
             (src_b_en_i[b] && src_b_i[b*RW+:RW] == dst_i[a*RW+:RW]);
        killed = 1'b0;
        for (int k = 0; k < W; k++)
          if (k > a && k < b && dst_en_i[k] && dst_i[k*RW+:RW] == dst_i[a*RW+:RW])
            killed = 1'b1;
        if (b > a)
          dep_o[a*W+b] = dst_en_i[a] && rd && !killed;
      end
    end
  end
endmodule

// File: rtl/mop_pair_select.sv
module mop_pair_select
  import mop_pkg::*;
#(
  parameter int W  = 8,
  parameter int RW = 5,
  localparam int OFF_W = $clog2(W),
  localparam int PTR_W = OFF_W + 1
) (
  input  logic [W*2-1:0]     cls_i,
  input  logic [W*RW-1:0]    dst_i,
  input  logic [W-1:0]       dst_en_i,
  input  logic [W*RW-1:0]    src_a_i,
  input  logic [W-1:0]       src_a_en_i,
  input  logic [W*RW-1:0]    src_b_i,
  input  logic [W-1:0]       src_b_en_i,
  input  logic [W-1:0]       taken_i,
  input  logic [W*W-1:0]     dep_i,
  input  logic               src3_mode_i,
  output logic [W*PTR_W-1:0] ptr_o
);
  logic [W-1:0] cand;
  logic [W-1:0] claimed;
  logic         found, out_e, in_e;
  int           tj, ntk, nsrc;

  always_comb
    for (int i = 0; i < W; i++)
      cand[i] = op_cls_e'(cls_i[2*i+:2]) != CLS_LONG;

  // greedy, oldest head first
  always_comb begin
    claimed = '0;
    ptr_o   = '0;
    found   = 1'b0;
    tj      = 0;
    ntk     = 0;
    nsrc    = 0;
    out_e   = 1'b0;
    in_e    = 1'b0;
    for (int i = 0; i < W; i++) begin
      found = 1'b0;
      tj    = 0;
      if (!claimed[i] && cand[i] && dst_en_i[i])
        for (int j = 0; j < W; j++)
          if (!found && j > i && cand[j] && !claimed[j] && dep_i[i*W+j]) begin
            found = 1'b1;
            tj    = j;
          end
      ntk   = 0;
      out_e = 1'b0;
      in_e  = 1'b0;
      for (int k = 0; k < W; k++) begin
        if (k >= i && k < tj && taken_i[k]) ntk = ntk + 1;
        if (k > i && k < tj) begin
          out_e = out_e | dep_i[i*W+k];
          in_e  = in_e  | dep_i[k*W+tj];
        end
      end
      nsrc = int'(src_a_en_i[i]) + int'(src_b_en_i[i])
           + int'(src_a_en_i[tj] && src_a_i[tj*RW+:RW] != dst_i[i*RW+:RW])
           + int'(src_b_en_i[tj] && src_b_i[tj*RW+:RW] != dst_i[i*RW+:RW]);
      if (found && ntk < 2 && !(out_e && in_e) && nsrc <= (src3_mode_i ? 3 : 2)) begin
        ptr_o[i*PTR_W+:PTR_W] = {ntk == 1, OFF_W'(tj - i)};
        claimed[i]  = 1'b1;
        claimed[tj] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mop_pair_detect.sv
module mop_pair_detect
  import mop_pkg::*;
#(
  parameter int W  = 8,
  parameter int RW = 5,
  localparam int OFF_W = $clog2(W),
  localparam int PTR_W = OFF_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               src3_mode_i,
  input  logic [W*2-1:0]     cls_i,
  input  logic [W*RW-1:0]    dst_i,
  input  logic [W-1:0]       dst_en_i,
  input  logic [W*RW-1:0]    src_a_i,
  input  logic [W-1:0]       src_a_en_i,
  input  logic [W*RW-1:0]    src_b_i,
  input  logic [W-1:0]       src_b_en_i,
  input  logic [W-1:0]       taken_i,
  output logic               ptr_valid_o,
  output logic [W*PTR_W-1:0] ptr_o
);
  logic [W*W-1:0]     dep;
  logic [W*PTR_W-1:0] ptr_nxt;

  mop_dep_matrix #(.W(W), .RW(RW)) u_dep (
    .dst_i      (dst_i),
    .dst_en_i   (dst_en_i),
    .src_a_i    (src_a_i),
    .src_a_en_i (src_a_en_i),
    .src_b_i    (src_b_i),
    .src_b_en_i (src_b_en_i),
    .dep_o      (dep)
  );

  mop_pair_select #(.W(W), .RW(RW)) u_sel (
    .cls_i       (cls_i),
    .dst_i       (dst_i),
    .dst_en_i    (dst_en_i),
    .src_a_i     (src_a_i),
    .src_a_en_i  (src_a_en_i),
    .src_b_i     (src_b_i),
    .src_b_en_i  (src_b_en_i),
    .taken_i     (taken_i),
    .dep_i       (dep),
    .src3_mode_i (src3_mode_i),
    .ptr_o       (ptr_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_valid_o <= 1'b0;
      ptr_o       <= '0;
    end else begin
      ptr_valid_o <= valid_i;
      if (valid_i) ptr_o <= ptr_nxt;
    end
  end

  // structural checks on the selector result
  logic             chk_rng, chk_tail, chk_cand, chk_off;
  logic [OFF_W-1:0] off;

  always_comb begin
    chk_rng  = 1'b0;
    chk_tail = 1'b0;
    chk_cand = 1'b0;
    chk_off  = 1'b0;
    off      = '0;
    for (int i = 0; i < W; i++) begin
      off = ptr_nxt[i*PTR_W+:OFF_W];
      if (ptr_nxt[i*PTR_W+:PTR_W] != '0 && off == '0) chk_off = 1'b1;
      if (off != '0) begin
        if (i + int'(off) >= W) chk_rng = 1'b1;
        if (op_cls_e'(cls_i[2*i+:2]) == CLS_LONG || !dst_en_i[i]) chk_cand = 1'b1;
        for (int j = 0; j < W; j++)
          if (j == i + int'(off)) begin
            if (ptr_nxt[j*PTR_W+:PTR_W] != '0) chk_tail = 1'b1;
            if (op_cls_e'(cls_i[2*j+:2]) == CLS_LONG) chk_cand = 1'b1;
          end
      end
    end
  end

  p_valid_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ptr_valid_o);
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!ptr_valid_o && $stable(ptr_o)));
  p_cand_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> !chk_cand);
  p_ptr_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> !chk_rng);
  p_ctrl_needs_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> !chk_off);
  p_tail_not_head_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> !chk_tail);
endmodule

// File: tb/sim_mop_pair_detect.sv
module sim_mop_pair_detect;
  localparam int W  = 8;
  localparam int RW = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid = 1'b0;
  logic            mode = 1'b0;
  logic [W*2-1:0]  cls = '0;
  logic [W*RW-1:0] dst = '0, sa = '0, sb = '0;
  logic [W-1:0]    den = '0, sae = '0, sbe = '0, tk = '0;
  logic            ptr_valid;
  logic [W*4-1:0]  ptr;

  // staging window
  logic [W*2-1:0]  s_cls;
  logic [W*RW-1:0] s_dst, s_sa, s_sb;
  logic [W-1:0]    s_den, s_sae, s_sbe, s_tk;
  logic            s_mode;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  mop_pair_detect u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .src3_mode_i(mode),
    .cls_i(cls), .dst_i(dst), .dst_en_i(den), .src_a_i(sa), .src_a_en_i(sae),
    .src_b_i(sb), .src_b_en_i(sbe), .taken_i(tk), .ptr_valid_o(ptr_valid), .ptr_o(ptr)
  );

  task automatic clr();
    s_cls = '0; s_dst = '0; s_sa = '0; s_sb = '0;
    s_den = '0; s_sae = '0; s_sbe = '0; s_tk = '0; s_mode = 1'b0;
  endtask

  task automatic slot(input int s, input logic [1:0] c, input logic de, input logic [4:0] d,
                      input logic ae, input logic [4:0] a, input logic be, input logic [4:0] b,
                      input logic t);
    s_cls[2*s+:2] = c; s_den[s] = de; s_dst[s*RW+:RW] = d;
    s_sae[s] = ae; s_sa[s*RW+:RW] = a; s_sbe[s] = be; s_sb[s*RW+:RW] = b; s_tk[s] = t;
  endtask

  task automatic apply(input logic v);
    cls = s_cls; dst = s_dst; den = s_den; sa = s_sa; sae = s_sae;
    sb = s_sb; sbe = s_sbe; tk = s_tk; mode = s_mode; valid = v;
  endtask

  task automatic send(input logic [31:0] e, input string tag);
    @(negedge clk);
    apply(1'b1);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic check(input logic ok, input string tag, input logic [31:0] got, input logic [31:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, e);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && ptr_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R1 unexpected result", ptr, 32'h0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(ptr === e, t, ptr, e);
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [1:0] ALU = 2'b00, CTL = 2'b01, STA = 2'b10, LNG = 2'b11;

  initial begin
    clr();
    apply(1'b0);
    repeat (3) @(negedge clk);
    check(ptr_valid === 1'b0 && ptr === '0, "R2 reset state", ptr, 32'h0);
    rst_n = 1'b1;

    // R4 R5 adjacent pair
    clr(); slot(0, ALU, 1, 1, 1, 2, 0, 0, 0); slot(1, ALU, 1, 3, 1, 1, 0, 0, 0);
    send(32'h1, "R4 R5 adjacent pair");
    // R6 nearest consumer wins
    clr(); slot(0, ALU, 1, 1, 0, 0, 0, 0, 0); slot(2, ALU, 0, 0, 1, 1, 0, 0, 0);
    slot(5, ALU, 0, 0, 0, 0, 1, 1, 0);
    send(32'h2, "R6 nearest consumer");
    // R3 long-latency slots skipped
    clr(); slot(0, ALU, 1, 1, 0, 0, 0, 0, 0); slot(1, LNG, 0, 0, 1, 1, 0, 0, 0);
    slot(3, ALU, 0, 0, 1, 1, 0, 0, 0); slot(4, LNG, 1, 5, 0, 0, 0, 0, 0);
    slot(5, ALU, 0, 0, 1, 5, 0, 0, 0);
    send(32'h3, "R3 long-latency excluded");
    // R5 intervening redefinition
    clr(); slot(0, ALU, 1, 1, 0, 0, 0, 0, 0); slot(1, ALU, 1, 1, 0, 0, 0, 0, 0);
    slot(2, ALU, 0, 0, 1, 1, 0, 0, 0);
    send(32'h10, "R5 redefinition kills edge");
    // R7 tail cannot head
    clr(); slot(0, ALU, 1, 1, 0, 0, 0, 0, 0); slot(1, ALU, 1, 2, 1, 1, 0, 0, 0);
    slot(2, ALU, 0, 0, 1, 2, 0, 0, 0);
    send(32'h1, "R7 tail not head");
    // R8 one taken transfer
    clr(); slot(0, ALU, 1, 1, 0, 0, 0, 0, 0); slot(1, CTL, 0, 0, 0, 0, 0, 0, 1);
    slot(2, ALU, 0, 0, 1, 1, 0, 0, 0);
    send(32'hA, "R8 one taken");
    // R8 two taken transfers
    clr(); slot(0, ALU, 1, 1, 0, 0, 0, 0, 0); slot(1, CTL, 0, 0, 0, 0, 0, 0, 1);
    slot(2, CTL, 0, 0, 0, 0, 0, 0, 1); slot(3, ALU, 0, 0, 1, 1, 0, 0, 0);
    send(32'h0, "R8 two taken");
    // R9 three sources, conventional then wide mode
    clr(); slot(0, ALU, 1, 1, 1, 2, 1, 3, 0); slot(1, ALU, 0, 0, 1, 1, 1, 4, 0);
    send(32'h0, "R9 three sources mode0");
    s_mode = 1'b1;
    send(32'h1, "R9 three sources mode1");
    // R9 both tail sources name head
    clr(); slot(0, ALU, 1, 1, 1, 2, 1, 3, 0); slot(1, ALU, 0, 0, 1, 1, 1, 1, 0);
    send(32'h1, "R9 shared sources");
    // R10 in and out edges
    clr(); slot(0, ALU, 1, 1, 0, 0, 0, 0, 0); slot(1, LNG, 1, 5, 1, 1, 0, 0, 0);
    slot(2, ALU, 0, 0, 1, 1, 1, 5, 0);
    send(32'h0, "R10 cycle rejected");
    // R10 incoming edge only
    clr(); slot(0, ALU, 1, 1, 0, 0, 0, 0, 0); slot(1, LNG, 1, 5, 0, 0, 0, 0, 0);
    slot(2, ALU, 0, 0, 1, 1, 1, 5, 0);
    send(32'h2, "R10 one edge allowed");
    // R4 maximum offset with second pair
    clr(); slot(0, ALU, 1, 1, 0, 0, 0, 0, 0); slot(2, ALU, 1, 9, 0, 0, 0, 0, 0);
    slot(3, ALU, 0, 0, 1, 9, 0, 0, 0); slot(7, ALU, 0, 0, 0, 0, 1, 1, 0);
    send(32'h107, "R4 offset seven");
    // R3 store and control classes
    clr(); slot(0, ALU, 1, 1, 0, 0, 0, 0, 0); slot(1, STA, 0, 0, 1, 1, 0, 0, 0);
    slot(3, CTL, 1, 7, 0, 0, 0, 0, 0); slot(4, ALU, 0, 0, 1, 7, 0, 0, 0);
    slot(5, ALU, 0, 0, 1, 20, 0, 0, 0);
    send(32'h1001, "R3 store and control");

    // R1 idle hold: present a pairable window without valid
    clr(); slot(0, ALU, 1, 1, 0, 0, 0, 0, 0); slot(1, ALU, 0, 0, 1, 1, 0, 0, 0);
    @(negedge clk); apply(1'b0);
    @(negedge clk);
    @(negedge clk);
    check(ptr_valid === 1'b0 && ptr === 32'h1001, "R1 idle hold", ptr, 32'h1001);
    check(exp_q.size() == 0, "R1 all results seen", 32'(exp_q.size()), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule